// File: doc/BRIEF.md
# Asymmetric Deglitch Alarm Event Sampler

This block conditions the digitized output of a threshold comparator. A high level on that input is the alarm condition. The block filters the signal with two delays. A rising edge must persist for a delay picked by a 3-bit code. That code is shared with a neighbouring fault channel, and this channel has no setting of its own. A falling edge must persist for a fixed four cycles. Each raw excursion that does not last long enough is rejected. The filter's count starts over whenever the raw input returns to the current filtered level.

The filtered state is read by a slow periodic sampler that runs on a one-cycle sample strobe. A qualified alarm is held in a stretch until a strobe has read it, so no alarm can slip between two samples. Recoveries are not stretched, so a recovery shorter than one sample period may never be seen. The sampled state drives an active-low, open-drain style output. A pull-low enable drives the line low during an alarm, and a level output shows the line as read with its pull-up. Nothing is latched: a captured recovery releases the line.

Top module: `alarm_deglitch_sampler`

## Requirements
- R1: After reset, alarmPullLow is 0 and alarmLevel is 1. They stay so across sample strobes while rawCmp remains low.
- R2: With riseSel = s, a high pulse on rawCmp lasting 2^s consecutive clocks qualifies as an alarm. A pulse of 2^s - 1 clocks is rejected. The code values 0 to 7 select 1, 2, 4, 8, 16, 32, 64 and 128 clocks.
- R3: If rawCmp returns to the filtered level before the delay has elapsed, the filter count restarts. Two 3-clock high pulses split by one low clock do not qualify when riseSel = 2.
- R4: A recovery needs rawCmp low for 4 consecutive clocks, whatever riseSel is. A low excursion of 3 clocks is rejected.
- R5: A qualified alarm is stretched until a sample strobe has read it. A single-clock alarm with riseSel = 0 is reported at a strobe that comes many cycles later. The following strobe reports recovery.
- R6: The output registers the stretched state only on clock edges where sampleStb is 1. The output never changes on other cycles.
- R7: A recovery that is filtered but is followed by a new alarm before the next strobe is not reported. The output stays in the alarm state across that strobe.
- R8: A captured alarm sets alarmPullLow = 1 and alarmLevel = 0. A captured recovery sets alarmPullLow = 0 and alarmLevel = 1. Nothing is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawCmp | input | 1 | Digitized comparator output; 1 means alarm condition |
| riseSel | input | 3 | Rising-edge filter code shared with the fault channel; delay is 2^riseSel clocks |
| sampleStb | input | 1 | One-cycle sample strobe marking each sample period |
| alarmPullLow | output | 1 | 1 enables the pull-low driver of the alarm line |
| alarmLevel | output | 1 | Alarm line level as read: 0 while driven low, 1 when released |

## Verification
The assertions check four rules on every cycle. The output changes only after a strobe. A strobe that sees a filtered or stretched alarm always leaves the line driven low. A stretch can end only on a strobe cycle. The filtered level moves only after the raw input has agreed with the new level on the preceding cycles. The exact lengths of the delays for each riseSel code can be shown only by the bench's scenarios. The same holds for the fixed falling delay, the restart of the count, the capture of a short alarm long after it has ended, and the loss of a short recovery.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef struct packed {
    logic setFilt;
    logic clrFilt;
    logic startStretch;
    logic endStretch;
  } almStrobes_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int FALL_DLY = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawCmp,
  input  logic [SEL_W-1:0] riseSel,
  input  logic             sampleStb,
  input  logic             filtLvl,
  input  logic             stretchOn,
  output almStrobes_t      stb
);
  localparam logic [CNT_W-1:0] FALL_TGT = CNT_W'(FALL_DLY);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] riseTgt;
  logic [CNT_W-1:0] tgt;
  logic             differ;
  logic             hit;

  always_comb begin
    riseTgt = CNT_W'(1) << riseSel;
    tgt     = filtLvl ? FALL_TGT : riseTgt;
    differ  = rawCmp ^ filtLvl;
    hit     = differ && (cnt == tgt - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (!differ || hit) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    stb.setFilt      = hit && !filtLvl;
    stb.clrFilt      = hit && filtLvl;
    stb.startStretch = hit && !filtLvl;
    stb.endStretch   = stretchOn && sampleStb && !(hit && !filtLvl);
  end
endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStb,
  input  almStrobes_t stb,
  output logic        filtLvl,
  output logic        stretchOn,
  output logic        sampled
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtLvl <= 1'b0;
    else if (stb.setFilt) filtLvl <= 1'b1;
    else if (stb.clrFilt) filtLvl <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stretchOn <= 1'b0;
    else if (stb.startStretch) stretchOn <= 1'b1;
    else if (stb.endStretch) stretchOn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampled <= 1'b0;
    else if (sampleStb) sampled <= filtLvl | stretchOn;
  end
endmodule

// File: rtl/alarm_deglitch_sampler.sv
module alarm_deglitch_sampler
  import alarm_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int FALL_DLY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawCmp,
  input  logic [SEL_W-1:0] riseSel,
  input  logic             sampleStb,
  output logic             alarmPullLow,
  output logic             alarmLevel
);
  localparam int MAX_DLY = 1 << ((1 << SEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DLY > FALL_DLY ? MAX_DLY : FALL_DLY) + 1;

  almStrobes_t stb;
  logic        filtLvl;
  logic        stretchOn;
  logic        sampled;

  alarm_ctrl #(.SEL_W(SEL_W), .FALL_DLY(FALL_DLY), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .riseSel(riseSel),
    .sampleStb(sampleStb), .filtLvl(filtLvl), .stretchOn(stretchOn), .stb(stb)
  );

  alarm_dp u_dp (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .stb(stb),
    .filtLvl(filtLvl), .stretchOn(stretchOn), .sampled(sampled)
  );

  assign alarmPullLow = sampled;
  assign alarmLevel   = ~sampled;
endmodule

// File: rtl/alarm_deglitch_sampler_chk.sv
module alarm_deglitch_sampler_chk (
  input logic clk,
  input logic rstN,
  input logic rawCmp,
  input logic sampleStb,
  input logic alarmPullLow,
  input logic filtLvl,
  input logic stretchOn
);
  // R6: output moves only after a strobe edge
  p_out_on_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleStb) |-> $stable(alarmPullLow));

  // R5: a strobe seeing filtered or stretched alarm captures it
  p_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && (filtLvl || stretchOn)) |=> alarmPullLow);

  // R5: stretch ends only on a strobe cycle
  p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stretchOn && !sampleStb) |=> stretchOn);

  // R2: filtered rise needs the raw input high before it
  p_rise_raw_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(filtLvl) |-> $past(rawCmp));

  // R4: filtered fall needs the raw input low on the two preceding edges
  p_fall_raw_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(filtLvl) |-> (!$past(rawCmp) && !$past(rawCmp, 2)));
endmodule

bind alarm_deglitch_sampler alarm_deglitch_sampler_chk u_chk (
  .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .sampleStb(sampleStb),
  .alarmPullLow(alarmPullLow), .filtLvl(filtLvl), .stretchOn(stretchOn)
);

// File: tb/alarm_deglitch_sampler_tb.sv
module alarm_deglitch_sampler_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawCmp = 1'b0;
  logic [2:0] riseSel = 3'd0;
  logic       sampleStb = 1'b0;
  logic       alarmPullLow;
  logic       alarmLevel;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_deglitch_sampler u_dut (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .riseSel(riseSel),
    .sampleStb(sampleStb), .alarmPullLow(alarmPullLow), .alarmLevel(alarmLevel)
  );

  task automatic checkOut(input string req, input logic expAlarm);
    testsRun++;
    if (alarmPullLow !== expAlarm || alarmLevel !== ~expAlarm) begin
      testsFailed++;
      $display("FAIL %s: pullLow=%b level=%b expected pullLow=%b level=%b",
               req, alarmPullLow, alarmLevel, expAlarm, ~expAlarm);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic pulse(input logic lvl, input int n);
    rawCmp = lvl;
    idle(n);
  endtask

  task automatic doReset();
    rstN = 1'b0; rawCmp = 1'b0; sampleStb = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic tReset();
    doReset();
    checkOut("R1 reset", 1'b0);
    strobe(); idle(3); strobe();
    checkOut("R1 quiet strobes", 1'b0);
  endtask

  task automatic tRiseDelay();
    doReset();
    riseSel = 3'd3;
    pulse(1'b1, 7); pulse(1'b0, 10);
    strobe();
    checkOut("R2 7-clk pulse sel3 rejected", 1'b0);
    pulse(1'b1, 8); pulse(1'b0, 10);
    checkOut("R6 no change before strobe", 1'b0);
    strobe();
    checkOut("R2 8-clk pulse sel3 qualifies", 1'b1);
    idle(5);
    strobe();
    checkOut("R8 recovery releases line", 1'b0);
    riseSel = 3'd7;
    pulse(1'b1, 127); pulse(1'b0, 10);
    strobe();
    checkOut("R2 127-clk pulse sel7 rejected", 1'b0);
    pulse(1'b1, 130);
    strobe();
    checkOut("R2 held high sel7 qualifies", 1'b1);
    pulse(1'b0, 3); pulse(1'b1, 2);
    strobe();
    checkOut("R4 3-clk low rejected with sel7", 1'b1);
    pulse(1'b0, 4);
    strobe();
    checkOut("R4 4-clk low recovers with sel7", 1'b0);
  endtask

  task automatic tRestart();
    doReset();
    riseSel = 3'd2;
    pulse(1'b1, 3); pulse(1'b0, 1); pulse(1'b1, 3); pulse(1'b0, 10);
    strobe();
    checkOut("R3 split pulses rejected", 1'b0);
    pulse(1'b1, 4); pulse(1'b0, 10);
    strobe();
    checkOut("R3 full pulse sel2 qualifies", 1'b1);
    strobe();
    checkOut("R8 not latched", 1'b0);
  endtask

  task automatic tStretch();
    doReset();
    riseSel = 3'd0;
    pulse(1'b1, 1); pulse(1'b0, 40);
    checkOut("R6 output idle before strobe", 1'b0);
    strobe();
    checkOut("R5 1-clk alarm captured late", 1'b1);
    idle(2);
    strobe();
    checkOut("R5 next strobe shows recovery", 1'b0);
  endtask

  task automatic tMissedRecovery();
    doReset();
    riseSel = 3'd0;
    pulse(1'b1, 3);
    strobe();
    checkOut("R8 alarm drives low", 1'b1);
    pulse(1'b0, 6); pulse(1'b1, 3);
    strobe();
    checkOut("R7 short recovery missed", 1'b1);
    rawCmp = 1'b0;
    idle(30);
    checkOut("R6 holds without strobe", 1'b1);
    strobe();
    checkOut("R6 strobe reports recovery", 1'b0);
  endtask

  initial begin
    fork
      begin
        tReset();
        tRiseDelay();
        tRestart();
        tStretch();
        tMissedRecovery();
        done = 1'b1;
      end
      begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
          testsRun++;
          testsFailed++;
          $display("FAIL watchdog: run hung, actual=timeout expected=done");
        end
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule